// File: doc/BRIEF.md
# Programmable 8 kHz Frame Pulse Generator

The block divides a synchronisation clock down to an 8 kHz frame rate and drives a single frame output. The frame output has one of two shapes. In square mode it is a 50% duty-cycle wave. In pulse mode it is a high-going pulse at the start of each frame, and the pulse lasts a programmed number of sync clock periods.

A small register write port sets two registers: a 4-bit pulse width and a 2-bit shape select. The write port also has a combinational read-back. Width and shape changes are held in shadow registers and reach the output only at the next frame boundary, so the frame in progress keeps its shape.

Top module: `frame_pulse_gen`

## Requirements
- R1: Rising edges of `frame_o` are exactly FRAME_LEN = SYNC_HZ/FRAME_HZ sync clock cycles apart (256 with defaults). A rising edge occurs only at a frame start.
- R2: With shape field 2'b00, 2'b10 or 2'b11, `frame_o` is high for the first FRAME_LEN/2 cycles of each frame (128 with defaults) and low for the rest.
- R3: With shape field 2'b01, `frame_o` is high for exactly W cycles at the start of each frame and low for the rest, where W is the width register value (1 to 15).
- R4: During reset `frame_o` is low, the width register reads 1 and the shape register reads 0 (square).
- R5: A write with width field bits [3:0] equal to 0 stores the value 1.
- R6: Address 0 holds the width in bits [3:0] and address 1 holds the shape in bits [1:0]. Written data in other bit positions is ignored, and those positions read back as zero.
- R7: A new width or shape written during a frame takes effect at the next frame start. The frame in progress keeps its width and shape, and a pulse in progress is never cut short.
- R8: The first sync clock edge after reset is released starts a frame, and `frame_o` goes high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synchronisation clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = width, 1 = shape |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read-back of the register selected by addr_i |
| frame_o | output | 1 | 8 kHz frame output |

## Verification
The bench writes a new width and a new shape in the middle of a frame. It then counts how long the current pulse stays high. A design that applied the write at once would cut a long pulse short, or would stretch a finished pulse into a square half-period.

Writing zero must give a one-cycle pulse. A design that stored zero would give no pulse at all. Writes with set reserved bits must read back masked, which catches a register that keeps the full byte.

The bench also checks the first cycle after reset and the period and high time in every shape encoding. These checks expose an off-by-one divider and a shape decode that treats the spare encodings wrongly.

// File: rtl/frame_gen_pkg.sv
package frame_gen_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned WID_W   = 4;
  localparam int unsigned SHAPE_W = 2;

  typedef enum logic [SHAPE_W-1:0] {
    SHAPE_SQUARE = 2'b00,
    SHAPE_PULSE  = 2'b01,
    SHAPE_SQ_B   = 2'b10,
    SHAPE_SQ_C   = 2'b11
  } shape_e;

  localparam logic [WID_W-1:0] WIDTH_RST = WID_W'(1);
endpackage

// File: rtl/frame_regs.sv
module frame_regs
  import frame_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [WID_W-1:0] width_o,
  output shape_e           shape_o
);
  logic [WID_W-1:0] width_q;
  shape_e           shape_q;
  logic [WID_W-1:0] width_wr;

  // zero width is normalised to one
  assign width_wr = (wr_data_i[WID_W-1:0] == '0) ? WIDTH_RST : wr_data_i[WID_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= WIDTH_RST;
      shape_q <= SHAPE_SQUARE;
    end else if (wr_en_i) begin
      if (addr_i) shape_q <= shape_e'(wr_data_i[SHAPE_W-1:0]);
      else        width_q <= width_wr;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i) rd_data_o[SHAPE_W-1:0] = shape_q;
    else        rd_data_o[WID_W-1:0]   = width_q;
  end

  assign width_o = width_q;
  assign shape_o = shape_q;

  // R5
  a_r5_zero_stored_as_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wr_data_i[WID_W-1:0] == '0) |=> (width_q == WIDTH_RST));
endmodule

// File: rtl/frame_divider.sv
module frame_divider #(
  parameter int unsigned FRAME_LEN = 256,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o     = (cnt_q == LAST);
  assign cnt_next_o = wrap_o ? '0 : cnt_q + 1'b1;

  // reset parks at the last count so the first edge opens a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= LAST;
    else         cnt_q <= cnt_next_o;
  end

  // R1
  a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/frame_shaper.sv
module frame_shaper
  import frame_gen_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 256,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic [WID_W-1:0] width_i,
  input  shape_e           shape_i,
  output logic             frame_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(FRAME_LEN / 2);

  logic [WID_W-1:0] act_width_q, act_width_d;
  shape_e           act_shape_q, act_shape_d;
  logic             frame_q, frame_d;

  // shadow values cross over only at the frame boundary
  always_comb begin
    act_width_d = wrap_i ? width_i : act_width_q;
    act_shape_d = wrap_i ? shape_i : act_shape_q;
    if (act_shape_d == SHAPE_PULSE)
      frame_d = cnt_next_i < {{(CNT_W-WID_W){1'b0}}, act_width_d};
    else
      frame_d = cnt_next_i < HALF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_width_q <= WIDTH_RST;
      act_shape_q <= SHAPE_SQUARE;
      frame_q     <= 1'b0;
    end else begin
      act_width_q <= act_width_d;
      act_shape_q <= act_shape_d;
      frame_q     <= frame_d;
    end
  end

  assign frame_o = frame_q;

  // R7
  a_r7_width_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_width_q));
  a_r7_shape_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_shape_q));
  // R1
  a_r1_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_q) |-> $past(wrap_i));
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
  import frame_gen_pkg::*;
#(
  parameter int unsigned SYNC_HZ  = 2_048_000,
  parameter int unsigned FRAME_HZ = 8_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             frame_o
);
  localparam int unsigned FRAME_LEN = SYNC_HZ / FRAME_HZ;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

  logic [WID_W-1:0] width;
  shape_e           shape;
  logic [CNT_W-1:0] cnt_next;
  logic             wrap;

  frame_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .width_o   (width),
    .shape_o   (shape)
  );

  frame_divider #(.FRAME_LEN(FRAME_LEN)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_next_o (cnt_next),
    .wrap_o     (wrap)
  );

  frame_shaper #(.FRAME_LEN(FRAME_LEN)) u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wrap),
    .cnt_next_i (cnt_next),
    .width_i    (width),
    .shape_i    (shape),
    .frame_o    (frame_o)
  );
endmodule

// File: tb/frame_pulse_gen_tb_top.sv
module frame_pulse_gen_tb_top;
  localparam int FLEN = 256;
  localparam int HALF = 128;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       frame_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  frame_pulse_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .frame_o(frame_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(logic a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic read_reg(logic a, output int d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = int'(rd_data_o);
  endtask

  task automatic sync_rise();
    logic p;
    p = frame_o;
    forever begin
      @(negedge clk_i);
      if (frame_o && !p) break;
      p = frame_o;
    end
  endtask

  task automatic measure(output int h, output int per);
    logic prev;
    bit in_high;
    sync_rise();
    h = 1; per = 1; prev = 1'b1; in_high = 1'b1;
    forever begin
      @(negedge clk_i);
      if (frame_o && !prev) break;
      per++;
      if (in_high && frame_o) h++; else in_high = 1'b0;
      prev = frame_o;
    end
  endtask

  task automatic count_high(output int h);
    h = 0;
    while (frame_o) begin
      h++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    int d;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R4 frame low in reset", int'(frame_o), 0);
    read_reg(1'b0, d); check("R4 width reset", d, 1);
    read_reg(1'b1, d); check("R4 shape reset", d, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 first edge starts frame", int'(frame_o), 1);
  endtask

  task automatic t_square(logic [7:0] code, string tag);
    int h, p;
    write_reg(1'b1, code);
    measure(h, p);
    check({tag, " square high"}, h, HALF);
    check("R1 period", p, FLEN);
  endtask

  task automatic t_pulse(int w);
    int h, p;
    write_reg(1'b0, 8'(w));
    write_reg(1'b1, 8'h01);
    measure(h, p);
    check("R3 pulse width", h, w);
    check("R1 pulse period", p, FLEN);
  endtask

  task automatic t_zero();
    int d, h, p;
    write_reg(1'b0, 8'h00);
    read_reg(1'b0, d); check("R5 zero reads one", d, 1);
    measure(h, p);     check("R5 zero gives one cycle", h, 1);
  endtask

  task automatic t_reserved();
    int d, h, p;
    write_reg(1'b0, 8'hF7);
    read_reg(1'b0, d); check("R6 width reserved masked", d, 7);
    measure(h, p);     check("R6 width from low bits", h, 7);
    write_reg(1'b1, 8'hFD);
    read_reg(1'b1, d); check("R6 shape reserved masked", d, 1);
  endtask

  task automatic t_defer_width();
    int h, p;
    write_reg(1'b0, 8'd15);
    write_reg(1'b1, 8'h01);
    sync_rise();
    sync_rise();
    write_reg(1'b0, 8'd2);
    count_high(h); check("R7 pulse not truncated", h, 13);
    measure(h, p); check("R7 new width next frame", h, 2);
  endtask

  task automatic t_defer_shape();
    int h, p;
    sync_rise();
    write_reg(1'b1, 8'h00);
    count_high(h); check("R7 shape held mid frame", h, 0);
    measure(h, p); check("R7 new shape next frame", h, HALF);
  endtask

  initial begin
    t_reset();
    t_square(8'h00, "R2");
    t_square(8'h02, "R2 code10");
    t_square(8'h03, "R2 code11");
    t_pulse(5);
    t_pulse(15);
    t_zero();
    t_reserved();
    t_defer_width();
    t_defer_shape();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule